// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block stores the eight sixteen-bit architectural registers of a small processor core. Four of them also appear as eight byte registers. A three-bit index and a width bit select the operand. With the width bit clear, the index names one whole word register. With the width bit set, the index names the upper or lower half of one of the first four registers. The byte view and the word view share the same storage, so a write to one half leaves the other half unchanged.

The file has two combinational read ports and one write port that updates on the rising clock edge. A separate output always presents the register that a loop instruction uses as its counter, so the execution logic can test that register without spending a read port. Inside the block, a decode stage turns the raw indices into per-byte write strobes and read selects, and a storage stage holds the registers and steers the data.

Top module: `gpRegFile`

## Requirements
- R1: A synchronous reset, sampled high at a rising edge, clears every register to zero.
- R2: In word mode, index values 0 through 7 select the registers accumulator, counter, data, base, stack pointer, frame pointer, source index and destination index, in that order. A word write stores all sixteen bits of the write data.
- R3: In byte mode, indices 0 to 3 select the low bytes of word registers 0 to 3. Indices 4 to 7 select the high bytes of word registers 0 to 3.
- R4: A byte write stores write data bits 7:0 into the addressed byte only. The other byte of that register, and every other register, keeps its value.
- R5: A byte read returns the addressed byte on read data bits 7:0, with bits 15:8 driven to zero.
- R6: Reads are combinational. A read of a register that is being written in the same cycle returns the value it held before the write. The new value is visible after the rising edge.
- R7: The two read ports work independently. Each port may use its own index and its own width in the same cycle.
- R8: The counter output always shows the full contents of word register 1.
- R9: While the write enable is low, no register changes, whatever is on the write index, width and data inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rdIdxA | input | 3 | Read port A register index |
| rdByteA | input | 1 | Read port A width: 1 = byte, 0 = word |
| rdDataA | output | 16 | Read port A data |
| rdIdxB | input | 3 | Read port B register index |
| rdByteB | input | 1 | Read port B width: 1 = byte, 0 = word |
| rdDataB | output | 16 | Read port B data |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 3 | Write register index |
| wrByte | input | 1 | Write width: 1 = byte, 0 = word |
| wrData | input | 16 | Write data; a byte write uses bits 7:0 |
| countOut | output | 16 | Current contents of the loop counter register |

## Verification
Two functions can fall in the same cycle: a write, and a read of the same storage through either view. For example, port A reads the word register while its high byte is written, or port B reads a byte while the whole word is written. The bench provokes this by placing the write target and both read indices on overlapping storage in one cycle. It checks that both ports and the counter output still show the value from before the edge. The following cycle must then show the merged result, with the untouched half preserved.

// File: rtl/grf_pkg.sv
package grf_pkg;
  localparam int WORD_W   = 16;
  localparam int BYTE_W   = WORD_W / 2;
  localparam int IDX_W    = 3;
  localparam int NUM_REGS = 1 << IDX_W;
  localparam int NUM_SPLIT = NUM_REGS / 2;
  localparam int COUNT_REG = 1;

  typedef struct packed {
    logic [NUM_REGS-1:0] loWe;
    logic [NUM_REGS-1:0] hiWe;
    logic                hiFromLow;
  } wrStrobe_t;

  typedef struct packed {
    logic [IDX_W-1:0] regSel;
    logic             hiHalf;
    logic             byteMode;
  } rdSel_t;

  typedef struct packed {
    wrStrobe_t wr;
    rdSel_t    rdA;
    rdSel_t    rdB;
  } grfCtl_t;
endpackage

// File: rtl/grfCtrl.sv
module grfCtrl
  import grf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrByte,
  input  logic [IDX_W-1:0] rdIdxA,
  input  logic             rdByteA,
  input  logic [IDX_W-1:0] rdIdxB,
  input  logic             rdByteB,
  output grfCtl_t          ctl
);
  localparam int SPLIT_W = IDX_W - 1;

  function automatic rdSel_t decodeRead(input logic [IDX_W-1:0] idx, input logic isByte);
    rdSel_t s;
    s.byteMode = isByte;
    if (isByte) begin
      s.regSel = {1'b0, idx[SPLIT_W-1:0]};
      s.hiHalf = idx[IDX_W-1];
    end else begin
      s.regSel = idx;
      s.hiHalf = 1'b0;
    end
    return s;
  endfunction

  logic [IDX_W-1:0] wrTarget;
  logic             wrHiOnly;
  logic             wrLoOnly;

  always_comb begin
    wrTarget = wrByte ? {1'b0, wrIdx[SPLIT_W-1:0]} : wrIdx;
    wrHiOnly = wrByte &  wrIdx[IDX_W-1];
    wrLoOnly = wrByte & ~wrIdx[IDX_W-1];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_strobe
    always_comb begin
      ctl.wr.loWe[g] = wrEn && (wrTarget == IDX_W'(g)) && !wrHiOnly;
      ctl.wr.hiWe[g] = wrEn && (wrTarget == IDX_W'(g)) && !wrLoOnly;
    end
  end

  always_comb begin
    ctl.wr.hiFromLow = wrHiOnly;
    ctl.rdA = decodeRead(rdIdxA, rdByteA);
    ctl.rdB = decodeRead(rdIdxB, rdByteB);
  end

  // R2
  lo_strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl.wr.loWe));
  // R2
  hi_strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl.wr.hiWe));
  // R4
  hi_byte_alone_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.wr.hiFromLow && (ctl.wr.hiWe != '0)) |-> (ctl.wr.loWe == '0));
  // R9
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !wrEn |-> ($countones({ctl.wr.loWe, ctl.wr.hiWe}) == 0));
endmodule

// File: rtl/grfData.sv
module grfData
  import grf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  grfCtl_t           ctl,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdDataA,
  output logic [WORD_W-1:0] rdDataB,
  output logic [WORD_W-1:0] countOut
);
  logic [WORD_W-1:0] regs [NUM_REGS];
  logic [BYTE_W-1:0] hiSrc;

  always_comb hiSrc = ctl.wr.hiFromLow ? wrData[BYTE_W-1:0] : wrData[WORD_W-1:BYTE_W];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else begin
        if (ctl.wr.loWe[g]) regs[g][BYTE_W-1:0]      <= wrData[BYTE_W-1:0];
        if (ctl.wr.hiWe[g]) regs[g][WORD_W-1:BYTE_W] <= hiSrc;
      end
    end

    // R4
    keep_hi_on_lo_write_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl.wr.loWe[g] && !ctl.wr.hiWe[g]) |=> $stable(regs[g][WORD_W-1:BYTE_W]));
    // R4
    keep_lo_on_hi_write_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl.wr.hiWe[g] && !ctl.wr.loWe[g]) |=> $stable(regs[g][BYTE_W-1:0]));
    // R9
    no_strobe_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (!ctl.wr.loWe[g] && !ctl.wr.hiWe[g]) |=> $stable(regs[g]));
  end

  function automatic logic [WORD_W-1:0] pick(input rdSel_t s, input logic [WORD_W-1:0] w);
    if (!s.byteMode) return w;
    if (s.hiHalf)    return {{BYTE_W{1'b0}}, w[WORD_W-1:BYTE_W]};
    return {{BYTE_W{1'b0}}, w[BYTE_W-1:0]};
  endfunction

  always_comb begin
    rdDataA  = pick(ctl.rdA, regs[ctl.rdA.regSel]);
    rdDataB  = pick(ctl.rdB, regs[ctl.rdB.regSel]);
    countOut = regs[COUNT_REG];
  end

  // R5
  zero_ext_a_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.rdA.byteMode |-> (rdDataA[WORD_W-1:BYTE_W] == '0));
  // R5
  zero_ext_b_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.rdB.byteMode |-> (rdDataB[WORD_W-1:BYTE_W] == '0));
endmodule

// File: rtl/gpRegFile.sv
module gpRegFile
  import grf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic              rdByteA,
  output logic [WORD_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic              rdByteB,
  output logic [WORD_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrByte,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] countOut
);
  grfCtl_t ctl;

  grfCtrl u_ctrl (
    .clk(clk), .rst(rst),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrByte(wrByte),
    .rdIdxA(rdIdxA), .rdByteA(rdByteA),
    .rdIdxB(rdIdxB), .rdByteB(rdByteB),
    .ctl(ctl)
  );

  grfData u_data (
    .clk(clk), .rst(rst), .ctl(ctl), .wrData(wrData),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .countOut(countOut)
  );

  // R1
  reset_clears_count_chk: assert property (@(posedge clk)
    rst |=> (countOut == '0));
  // R8
  count_word_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !wrByte && wrIdx == IDX_W'(COUNT_REG)) |=> (countOut == $past(wrData)));
endmodule

// File: tb/sim_gpRegFile.sv
`timescale 1ns/100ps
module sim_gpRegFile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  rdIdxA = '0, rdIdxB = '0, wrIdx = '0;
  logic        rdByteA = 1'b0, rdByteB = 1'b0, wrByte = 1'b0, wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdDataA, rdDataB, countOut;

  always #2.5 clk = ~clk;

  gpRegFile u0 (
    .clk(clk), .rst(rst),
    .rdIdxA(rdIdxA), .rdByteA(rdByteA), .rdDataA(rdDataA),
    .rdIdxB(rdIdxB), .rdByteB(rdByteB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrByte(wrByte), .wrData(wrData),
    .countOut(countOut)
  );

  typedef struct {
    logic [15:0] expA, expB, expCnt;
    string       tag;
  } exp_t;

  exp_t        sbQ[$];
  event        sampleEv;
  logic [15:0] model [8];
  int          nChecks = 0;
  int          nFails  = 0;

  function automatic logic [15:0] refRead(input logic [2:0] idx, input logic isByte);
    if (!isByte) return model[idx];
    if (idx < 3'd4) return {8'h00, model[idx[1:0]][7:0]};
    return {8'h00, model[idx[1:0]][15:8]};
  endfunction

  task automatic compare(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(sampleEv);
      while (sbQ.size() > 0) begin
        e = sbQ.pop_front();
        compare(e.tag, "portA", rdDataA, e.expA);
        compare(e.tag, "portB", rdDataB, e.expB);
        compare(e.tag, "count", countOut, e.expCnt);
      end
    end
  end

  task automatic step(input logic we, input logic [2:0] wi, input logic wb, input logic [15:0] wd,
                      input logic [2:0] ia, input logic ba, input logic [2:0] ib, input logic bb,
                      input string tag);
    exp_t e;
    @(negedge clk);
    wrEn = we; wrIdx = wi; wrByte = wb; wrData = wd;
    rdIdxA = ia; rdByteA = ba; rdIdxB = ib; rdByteB = bb;
    #1;
    e.expA = refRead(ia, ba);
    e.expB = refRead(ib, bb);
    e.expCnt = model[1];
    e.tag = tag;
    sbQ.push_back(e);
    ->sampleEv;
    if (we) begin
      if (!wb) model[wi] = wd;
      else if (wi < 3'd4) model[wi[1:0]][7:0] = wd[7:0];
      else model[wi[1:0]][15:8] = wd[7:0];
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; wrEn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin : watchdog
    #(5.0 * 20000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin : driver
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: everything reads zero after reset
    for (int i = 0; i < 8; i += 2)
      step(1'b0, 3'd0, 1'b0, 16'h0, 3'(i), 1'b0, 3'(i + 1), 1'b0, "R1 reset state");
    // R2 R6: word writes, same-index read returns old value
    for (int i = 0; i < 8; i++)
      step(1'b1, 3'(i), 1'b0, 16'h1111 * 16'(i + 1) ^ 16'hA5C3, 3'(i), 1'b0, 3'((i + 7) % 8), 1'b0,
           "R2 R6 word write");
    // R2 R7 R8: word readback on both ports
    for (int i = 0; i < 8; i++)
      step(1'b0, 3'd0, 1'b0, 16'h0, 3'(i), 1'b0, 3'(7 - i), 1'b0, "R2 R7 R8 word read");
    // R3 R5 R7: byte reads, mixed widths across the ports
    for (int i = 0; i < 8; i++)
      step(1'b0, 3'd0, 1'b0, 16'h0, 3'(i), 1'b1, 3'(i), 1'b0, "R3 R5 R7 byte read");
    // R4: byte writes with junk in the upper data bits
    for (int i = 0; i < 8; i++)
      step(1'b1, 3'(i), 1'b1, {8'hEE, 8'(8'h30 + i)}, 3'(i % 4), 1'b0, 3'(i), 1'b1, "R4 byte write");
    for (int i = 0; i < 4; i++)
      step(1'b0, 3'd0, 1'b0, 16'h0, 3'(i), 1'b0, 3'(i + 4), 1'b0, "R4 word view after byte write");
    // R6: same-cycle overlap between byte write and word read, and vice versa
    step(1'b1, 3'd5, 1'b1, 16'h00C4, 3'd1, 1'b0, 3'd5, 1'b1, "R6 hi byte write vs word read");
    step(1'b0, 3'd0, 1'b0, 16'h0, 3'd1, 1'b0, 3'd1, 1'b1, "R6 R8 after hi byte write");
    step(1'b1, 3'd1, 1'b0, 16'hBEEF, 3'd5, 1'b1, 3'd1, 1'b1, "R6 word write vs byte reads");
    step(1'b0, 3'd0, 1'b0, 16'h0, 3'd5, 1'b1, 3'd1, 1'b1, "R6 R8 after word write");
    // R9: write enable low with live data
    for (int i = 0; i < 8; i++)
      step(1'b0, 3'(i), 1'(i % 2), 16'hFFFF, 3'(i), 1'b0, 3'(i), 1'b1, "R9 disabled write");
    for (int i = 0; i < 8; i++)
      step(1'b0, 3'd0, 1'b0, 16'h0, 3'(i), 1'b0, 3'((i + 3) % 8), 1'b0, "R9 state after idle");
    // R1: mid-run reset
    doReset();
    for (int i = 0; i < 8; i++)
      step(1'b0, 3'd0, 1'b0, 16'h0, 3'(i), 1'b0, 3'(i), 1'b1, "R1 reset mid run");
    @(negedge clk);
    #1;
    finishRun();
  end
endmodule